// File: doc/BRIEF.md
# Segmented Read-Allocate Data Cache

This block is a data cache placed between a 32-bit core load/store port and a slower memory port that moves one word per request. Storage is split into four segments. The address bits just above the word offset pick the segment, and inside a segment every row is compared by tag, so a line may sit in any row of its segment. Lines hold eight words.

Only read misses bring lines in. Write misses, write-through hits and the contents of dirty victims go to memory through a posted write buffer of eight words, and the core waits on a write only when that buffer is full. A per-access policy input chooses between write-back and write-through handling of write hits. The replacement row comes from a counter that advances every clock and never goes below a programmable lockdown row, so rows under that boundary hold their contents. A cache-enable input sends every access straight to memory, and a strobe drops every line at once.

Top module: `dcache_seg`

## Requirements
- R1: The segment is address bits [6:5]. A read that hits is acknowledged in the cycle it is requested, returns the cached word and starts no memory transfer.
- R2: A read miss reads the eight words of the line from memory with word offset 0 first and counting up, returns the requested word afterwards, and later reads of that line hit.
- R3: A write miss loads no line: the word reaches memory through the buffer, and a later read of that address misses.
- R4: A write hit with `cpu_wb`=1 (write-back) updates the cached word, marks the line dirty and sends nothing to memory.
- R5: A write hit with `cpu_wb`=0 (write-through) updates the cached word and also sends it to memory.
- R6: A write that is not preceded by an accepted write and needs no buffer space is acknowledged in its request cycle. A write requested in the cycle after another write was accepted waits one more cycle.
- R7: The buffer holds up to eight words and writes them to memory in the order accepted. The core waits on a write only while the buffer is full.
- R8: The replacement row is taken from a counter that runs over rows `lock_row` to 15. Rows below `lock_row` are never replaced.
- R9: On a read miss whose victim is dirty, all eight words of the victim, with their written values, are queued to memory before the new line is filled.
- R10: No read goes to memory while the buffer holds a word of the same line, so a read always sees the most recent write.
- R11: With `cache_en`=0 a read performs one memory read and a write goes through the buffer. The cache contents are not changed.
- R12: A one-cycle pulse on `inval_all` invalidates every line, so the next read of any line misses.
- R13: Once `mem_req` is raised, it stays high with `mem_we` and `mem_addr` unchanged until `mem_ack` is seen.
- R14: Out of reset, `cpu_ack` and `mem_req` are low and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 = use the cache, 0 = send every access to memory |
| inval_all | input | 1 | Strobe that clears every valid bit |
| lock_row | input | 4 | Lowest row that replacement may choose |
| cpu_req | input | 1 | Core access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wb | input | 1 | Write-hit policy: 1 = write-back, 0 = write-through |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes one word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The hardest case to produce is a read that reaches memory while the buffer still holds a write to the same line, because the buffer normally drains before the core can ask again. The bench sends two write misses to one line back to back and then reads that line at once. The memory model answers only after several cycles, so both words are still queued when the read arrives. Random replacement is made predictable by setting the lockdown row to the last row: every miss in that segment then has to use the same row, which allows a known dirty line to be evicted.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_WAIT,
    ST_MEM,
    ST_BDONE
  } dcs_state_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } wb_entry_t;
endpackage

// File: rtl/dcs_wbuf.sv
`timescale 1ns/1ps
module dcs_wbuf
  import dcs_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int CMP_LSB = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  wb_entry_t             push_ent,
  input  logic                  pop,
  output wb_entry_t             head,
  output logic                  empty,
  output logic                  full,
  output logic [CW-1:0]         count,
  input  logic [31-CMP_LSB:0]   probe,
  output logic                  match
);
  wb_entry_t        ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = ent_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;

  always_comb begin
    match = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && ent_q[i].addr[31:CMP_LSB] == probe) match = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) ent_q[wr_q] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= nxt(rd_q);
      end
      if (push) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= nxt(wr_q);
      end
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/dcs_victim.sv
`timescale 1ns/1ps
module dcs_victim #(
  parameter int ROWS = 16,
  localparam int RB = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RB-1:0] lock,
  output logic [RB-1:0] victim
);
  logic [RB-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                     cnt_q <= '0;
    else if (cnt_q < lock || cnt_q == RB'(ROWS - 1)) cnt_q <= lock;
    else                                            cnt_q <= cnt_q + 1'b1;
  end

  assign victim = (cnt_q < lock) ? lock : cnt_q;
endmodule

// File: rtl/dcs_lookup.sv
`timescale 1ns/1ps
module dcs_lookup #(
  parameter int ROWS  = 16,
  parameter int TAG_W = 25,
  localparam int RB = $clog2(ROWS)
) (
  input  logic [ROWS-1:0]            vld,
  input  logic [ROWS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [RB-1:0]              row
);
  always_comb begin
    hit = 1'b0;
    row = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (vld[i] && tags[i] == tag) begin
        hit = 1'b1;
        row = i[RB-1:0];
      end
    end
  end
endmodule

// File: rtl/dcache_seg.sv
`timescale 1ns/1ps
module dcache_seg
  import dcs_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int ROWS       = 16,
  parameter int SEGS       = 4,
  parameter int WB_DEPTH   = 8,
  localparam int WOFF    = $clog2(LINE_WORDS),
  localparam int SB      = $clog2(SEGS),
  localparam int RB      = $clog2(ROWS),
  localparam int SEG_LSB = 2 + WOFF,
  localparam int TAG_LSB = SEG_LSB + SB,
  localparam int TAG_W   = 32 - TAG_LSB,
  localparam int IDX_W   = SB + RB + WOFF,
  localparam int NWORDS  = SEGS * ROWS * LINE_WORDS,
  localparam int CW      = $clog2(WB_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cache_en,
  input  logic          inval_all,
  input  logic [RB-1:0] lock_row,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_wb,
  input  logic [31:0]   cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_ack,
  output logic [31:0]   cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  function automatic logic [IDX_W-1:0] didx(input logic [SB-1:0] s,
                                            input logic [RB-1:0] r,
                                            input logic [WOFF-1:0] w);
    return {s, r, w};
  endfunction

  function automatic logic [31:0] line_word(input logic [TAG_W-1:0] t,
                                            input logic [SB-1:0] s,
                                            input logic [WOFF-1:0] w);
    return {t, s, w, 2'b00};
  endfunction

  localparam logic [WOFF-1:0] LAST_W = WOFF'(LINE_WORDS - 1);

  // storage
  logic [31:0]                      data_q [NWORDS];
  logic [SEGS-1:0][ROWS-1:0]        valid_q, dirty_q;
  logic [SEGS-1:0][ROWS-1:0][TAG_W-1:0] tag_q;

  // control state
  dcs_state_e      state_q;
  logic [SB-1:0]   m_seg;
  logic [RB-1:0]   m_row;
  logic [TAG_W-1:0] m_tag;
  logic [WOFF-1:0] m_cnt;
  logic            m_byp;
  logic [31:0]     m_waddr;
  logic [31:0]     byp_q;
  logic            prev_wr_q;
  logic            wr_busy_q;

  // address fields
  logic [SB-1:0]    seg_s;
  logic [TAG_W-1:0] tag_s;
  logic [WOFF-1:0]  w_s;
  assign seg_s = cpu_addr[SEG_LSB +: SB];
  assign tag_s = cpu_addr[TAG_LSB +: TAG_W];
  assign w_s   = cpu_addr[2 +: WOFF];

  logic          hit;
  logic [RB-1:0] hit_row;
  logic [RB-1:0] victim;

  dcs_lookup #(.ROWS(ROWS), .TAG_W(TAG_W)) u_lookup (
    .vld (valid_q[seg_s]),
    .tags(tag_q[seg_s]),
    .tag (tag_s),
    .hit (hit),
    .row (hit_row)
  );

  dcs_victim #(.ROWS(ROWS)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .lock  (lock_row),
    .victim(victim)
  );

  // write buffer
  wb_entry_t     wb_head, wb_in;
  logic          wb_push, wb_pop, wb_empty, wb_full, wb_match;
  logic [CW-1:0] wb_count;

  dcs_wbuf #(.DEPTH(WB_DEPTH), .CMP_LSB(SEG_LSB)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wb_push),
    .push_ent(wb_in),
    .pop     (wb_pop),
    .head    (wb_head),
    .empty   (wb_empty),
    .full    (wb_full),
    .count   (wb_count),
    .probe   ({m_tag, m_seg}),
    .match   (wb_match)
  );

  // named events
  logic in_idle, rd_hit, miss_start, byp_start;
  logic wr_hit, wr_push_need, wr_acc, ev_push;
  logic drain_req, fill_req, fill_ack, fill_last;

  assign in_idle      = (state_q == ST_IDLE);
  assign rd_hit       = in_idle && cpu_req && !cpu_we && cache_en && hit;
  assign miss_start   = in_idle && cpu_req && !cpu_we && cache_en && !hit;
  assign byp_start    = in_idle && cpu_req && !cpu_we && !cache_en;
  assign wr_hit       = cache_en && hit;
  assign wr_push_need = !(wr_hit && cpu_wb);
  assign wr_acc       = in_idle && cpu_req && cpu_we && !prev_wr_q &&
                        (!wr_push_need || !wb_full);
  assign ev_push      = (state_q == ST_EVICT) && !wb_full;

  assign cpu_ack   = rd_hit || wr_acc || (state_q == ST_BDONE);
  assign cpu_rdata = (state_q == ST_BDONE) ? byp_q : data_q[didx(seg_s, hit_row, w_s)];

  assign wb_push = (wr_acc && wr_push_need) || ev_push;
  always_comb begin
    if (state_q == ST_EVICT) begin
      wb_in.addr = line_word(tag_q[m_seg][m_row], m_seg, m_cnt);
      wb_in.data = data_q[didx(m_seg, m_row, m_cnt)];
    end else begin
      wb_in.addr = cpu_addr & 32'hFFFF_FFFC;
      wb_in.data = cpu_wdata;
    end
  end

  // memory port: the write buffer drains unless a fill owns the port
  assign drain_req = !wb_empty && ((state_q != ST_MEM) || wr_busy_q);
  assign fill_req  = (state_q == ST_MEM) && !wr_busy_q;
  assign fill_ack  = fill_req && mem_ack;
  assign fill_last = (m_cnt == LAST_W);
  assign wb_pop    = drain_req && mem_ack;

  assign mem_req   = drain_req || fill_req;
  assign mem_we    = drain_req;
  assign mem_wdata = wb_head.data;
  assign mem_addr  = drain_req ? wb_head.addr :
                     (m_byp ? m_waddr : line_word(m_tag, m_seg, m_cnt));

  always_ff @(posedge clk) begin
    if (wr_acc && wr_hit)
      data_q[didx(seg_s, hit_row, w_s)] <= cpu_wdata;
    else if (fill_ack && !m_byp)
      data_q[didx(m_seg, m_row, m_cnt)] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      valid_q   <= '0;
      dirty_q   <= '0;
      tag_q     <= '0;
      m_seg     <= '0;
      m_row     <= '0;
      m_tag     <= '0;
      m_cnt     <= '0;
      m_byp     <= 1'b0;
      m_waddr   <= '0;
      byp_q     <= '0;
      prev_wr_q <= 1'b0;
      wr_busy_q <= 1'b0;
    end else begin
      prev_wr_q <= wr_acc;
      wr_busy_q <= drain_req && !mem_ack;
      unique case (state_q)
        ST_IDLE: begin
          if (miss_start) begin
            m_seg <= seg_s;
            m_row <= victim;
            m_tag <= tag_s;
            m_cnt <= '0;
            m_byp <= 1'b0;
            valid_q[seg_s][victim] <= 1'b0;
            state_q <= (valid_q[seg_s][victim] && dirty_q[seg_s][victim]) ? ST_EVICT : ST_WAIT;
          end else if (byp_start) begin
            m_seg   <= seg_s;
            m_tag   <= tag_s;
            m_byp   <= 1'b1;
            m_waddr <= cpu_addr & 32'hFFFF_FFFC;
            state_q <= ST_WAIT;
          end
          if (wr_acc && wr_hit && cpu_wb) dirty_q[seg_s][hit_row] <= 1'b1;
        end
        ST_EVICT: begin
          if (ev_push) begin
            m_cnt <= fill_last ? '0 : m_cnt + 1'b1;
            if (fill_last) state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!wb_match) state_q <= ST_MEM;
        end
        ST_MEM: begin
          if (fill_ack) begin
            if (m_byp) begin
              byp_q   <= mem_rdata;
              state_q <= ST_BDONE;
            end else if (fill_last) begin
              valid_q[m_seg][m_row] <= 1'b1;
              dirty_q[m_seg][m_row] <= 1'b0;
              tag_q[m_seg][m_row]   <= m_tag;
              m_cnt   <= '0;
              state_q <= ST_IDLE;
            end else begin
              m_cnt <= m_cnt + 1'b1;
            end
          end
        end
        ST_BDONE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
      if (inval_all) begin
        valid_q <= '0;
        dirty_q <= '0;
      end
    end
  end
endmodule

// File: rtl/dcs_chk.sv
`timescale 1ns/1ps
module dcs_chk #(
  parameter int N     = 64,
  parameter int RB    = 4,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_wb,
  input logic          cpu_ack,
  input logic [N-1:0]  valid_bits,
  input logic [N-1:0]  dirty_bits,
  input logic [CW-1:0] wb_count,
  input logic          wb_match,
  input logic          fill_req,
  input logic          miss_start,
  input logic [RB-1:0] victim,
  input logic [RB-1:0] lock_row
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R13
  AST_NO_WR_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && cpu_ack |=> $countones(valid_bits) <= $past($countones(valid_bits))); // R3
  AST_DIRTY_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dirty_bits) > $past($countones(dirty_bits)) |-> $past(cpu_req && cpu_we && cpu_ack && cpu_wb)); // R4
  AST_WB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= CW'(DEPTH)); // R7
  AST_FILL_NO_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !wb_match); // R10
  AST_VICTIM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start |-> victim >= lock_row); // R8
endmodule

bind dcache_seg dcs_chk #(
  .N(SEGS * ROWS), .RB(RB), .CW(CW), .DEPTH(WB_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_wb    (cpu_wb),
  .cpu_ack   (cpu_ack),
  .valid_bits(valid_q),
  .dirty_bits(dirty_q),
  .wb_count  (wb_count),
  .wb_match  (wb_match),
  .fill_req  (fill_req),
  .miss_start(miss_start),
  .victim    (victim),
  .lock_row  (lock_row)
);

// File: tb/dcache_seg_test.sv
`timescale 1ns/1ps
module dcache_seg_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1, inval_all = 1'b0;
  logic [3:0]  lock_row = 4'd0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wb = 1'b1;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  dcache_seg uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0, hold_viol = 0;

  // memory model with access log
  logic [31:0] mem_arr [logic [31:0]];
  bit          lg_we   [$];
  logic [31:0] lg_addr [$];
  logic [31:0] lg_data [$];
  int          lat_cnt = 0;
  bit          hold_pend = 0;
  logic [31:0] h_addr;
  logic        h_we;

  function automatic logic [31:0] mval(input logic [31:0] a);
    return (a * 32'd7) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mread(input logic [31:0] a);
    return mem_arr.exists(a) ? mem_arr[a] : mval(a);
  endfunction

  always @(negedge clk) begin
    if (hold_pend && (!mem_req || mem_addr !== h_addr || mem_we !== h_we)) hold_viol++;
    if (!rst_n) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      lat_cnt++;
      if (lat_cnt == LAT) begin
        mem_ack = 1'b1;
        lg_we.push_back(mem_we);
        lg_addr.push_back(mem_addr);
        if (mem_we) begin
          mem_arr[mem_addr] = mem_wdata;
          lg_data.push_back(mem_wdata);
        end else begin
          mem_rdata = mread(mem_addr);
          lg_data.push_back(mem_rdata);
        end
      end
    end
    hold_pend = rst_n && mem_req && !mem_ack;
    h_addr = mem_addr;
    h_we = mem_we;
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    lg_we.delete(); lg_addr.delete(); lg_data.delete();
  endtask

  function automatic int n_ops(input bit we);
    int n = 0;
    foreach (lg_we[i]) if (lg_we[i] == we) n++;
    return n;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one core access, started and ended at a falling edge
  task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input bit wb, output logic [31:0] rd, output int waits);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_wb = wb;
    waits = 0;
    #1;
    while (!cpu_ack && waits < 5000) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0000_1000; // segment 0
  localparam logic [31:0] C = 32'h0000_2020; // segment 1
  localparam logic [31:0] X = 32'h0000_3040; // segment 2
  localparam logic [31:0] Y = 32'h0000_5040; // segment 2
  localparam logic [31:0] H = 32'h0000_7060; // segment 3
  localparam logic [31:0] D = 32'h0000_9000;

  task automatic t_reset();
    #1;
    chk("R14 cpu_ack after reset", {31'd0, cpu_ack}, 32'd0);
    chk("R14 mem_req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_read_miss_hit();
    logic [31:0] rd; int w, bad;
    clear_log();
    cpu_op(0, A + 8, 0, 1, rd, w);
    chk("R2 miss data", rd, mval(A + 8));
    bad = 0;
    for (int k = 0; k < 8; k++)
      if (k >= lg_addr.size() || lg_we[k] || lg_addr[k] !== A + 4 * k) bad++;
    chk("R2 fill order", bad, 0);
    chk("R2 fill count", lg_addr.size(), 8);
    clear_log();
    cpu_op(0, A + 12, 0, 1, rd, w);
    chk("R1 hit data", rd, mval(A + 12));
    chk("R1 hit same cycle", w, 0);
    chk("R1 hit no memory", lg_addr.size(), 0);
  endtask

  task automatic t_wb_hit();
    logic [31:0] rd; int w;
    clear_log();
    cpu_op(1, A + 8, 32'h0000_0011, 1, rd, w);
    chk("R6 isolated write hit", w, 0);
    idle(30);
    chk("R4 no memory write", n_ops(1), 0);
    cpu_op(0, A + 8, 0, 1, rd, w);
    chk("R4 cached value", rd, 32'h0000_0011);
  endtask

  task automatic t_wt_hit();
    logic [31:0] rd; int w;
    clear_log();
    cpu_op(1, A + 16, 32'h0000_0022, 0, rd, w);
    idle(30);
    chk("R5 one memory write", n_ops(1), 1);
    chk("R5 memory value", mread(A + 16), 32'h0000_0022);
    cpu_op(0, A + 16, 0, 1, rd, w);
    chk("R5 cached value", rd, 32'h0000_0022);
    chk("R5 still hit", w, 0);
  endtask

  task automatic t_b2b();
    logic [31:0] rd; int w1, w2;
    cpu_op(1, A + 20, 32'h33, 1, rd, w1);
    cpu_op(1, A + 24, 32'h44, 1, rd, w2);
    chk("R6 first write", w1, 0);
    chk("R6 second write waits", w2, 1);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int w;
    clear_log();
    cpu_op(1, C, 32'h77, 1, rd, w);
    idle(30);
    chk("R3 memory written", mread(C), 32'h77);
    clear_log();
    cpu_op(0, C, 0, 1, rd, w);
    chk("R3 read misses", n_ops(0), 8);
    chk("R3 read data", rd, 32'h77);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int w, bad;
    lock_row = 4'd15;
    cpu_op(0, X, 0, 1, rd, w);
    cpu_op(1, X + 4, 32'hD1, 1, rd, w);
    clear_log();
    cpu_op(0, Y + 8, 0, 1, rd, w);
    chk("R9 new line data", rd, mval(Y + 8));
    idle(40);
    bad = 0;
    for (int k = 0; k < 8; k++)
      if (mread(X + 4 * k) !== ((k == 1) ? 32'hD1 : mval(X + 4 * k))) bad++;
    chk("R9 victim words written", bad, 0);
    chk("R9 eviction write count", n_ops(1), 8);
  endtask

  task automatic t_lock();
    logic [31:0] rd; int w;
    clear_log();
    cpu_op(0, X + 4, 0, 1, rd, w);
    chk("R8 X misses", n_ops(0), 8);
    chk("R8 X data", rd, 32'hD1);
    clear_log();
    cpu_op(0, Y, 0, 1, rd, w);
    chk("R8 Y misses", n_ops(0), 8);
    clear_log();
    cpu_op(0, X, 0, 1, rd, w);
    chk("R8 X misses again", n_ops(0), 8);
    lock_row = 4'd0;
  endtask

  task automatic t_hazard();
    logic [31:0] rd; int w;
    cpu_op(1, H, 32'hAB, 1, rd, w);
    cpu_op(1, H + 4, 32'hCD, 1, rd, w);
    cpu_op(0, H + 4, 0, 1, rd, w);
    chk("R10 read after queued write", rd, 32'hCD);
    cpu_op(0, H, 0, 1, rd, w);
    chk("R10 line holds first write", rd, 32'hAB);
  endtask

  task automatic t_full();
    logic [31:0] rd; int w, tw, bad;
    clear_log();
    tw = 0;
    for (int i = 0; i < 20; i++) begin
      cpu_op(1, D + 4 * i, 32'h100 + i, 1, rd, w);
      tw += w;
    end
    tests++;
    if (tw <= 19) begin
      fails++;
      $display("FAIL R7 no stall when full act=%0d exp>19", tw);
    end
    idle(120);
    chk("R7 all drained", n_ops(1), 20);
    bad = 0;
    for (int k = 0; k < 20; k++)
      if (k >= lg_addr.size() || lg_addr[k] !== D + 4 * k || lg_data[k] !== 32'h100 + k) bad++;
    chk("R7 drain order", bad, 0);
  endtask

  task automatic t_bypass();
    logic [31:0] rd; int w;
    cache_en = 1'b0;
    clear_log();
    cpu_op(0, A + 8, 0, 1, rd, w);
    chk("R11 bypass read from memory", rd, mval(A + 8));
    chk("R11 single memory read", n_ops(0), 1);
    cpu_op(1, A + 28, 32'hEE, 1, rd, w);
    idle(30);
    chk("R11 bypass write in memory", mread(A + 28), 32'hEE);
    cache_en = 1'b1;
    clear_log();
    cpu_op(0, A + 28, 0, 1, rd, w);
    chk("R11 cache untouched", rd, mval(A + 28));
    chk("R11 still hit", n_ops(0), 0);
  endtask

  task automatic t_inval();
    logic [31:0] rd; int w;
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    clear_log();
    cpu_op(0, A + 12, 0, 1, rd, w);
    chk("R12 miss after invalidate", n_ops(0), 8);
    chk("R12 data", rd, mval(A + 12));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    t_read_miss_hit();
    t_wb_hit();
    t_wt_hit();
    t_b2b();
    t_write_miss();
    t_dirty_evict();
    t_lock();
    t_hazard();
    t_full();
    t_bypass();
    t_inval();
    idle(5);
    chk("R13 memory handshake held", hold_viol, 0);
    finish_run();
  end
endmodule